// File: doc/BRIEF.md
# Converter Self-Calibration Controller

This block sequences the calibration of a successive-approximation converter built around a capacitor DAC. A start command launches one of two runs. A short run measures only the zero error once. A long run measures the zero error and then the weight error of every DAC capacitor. Each step of a run takes its DAC setting from a small pattern ROM. The controller places that setting on its output and raises a one-cycle request. The analog side then returns a signed error count for the measurement.

In the long run every measurement is repeated eight times. The signed sum is reduced to an average by an arithmetic shift. Each capacitor is tested against the sum of all smaller capacitors, starting from the most significant capacitor and working down. Results land in a bank of fourteen coefficient registers: one for zero error and thirteen for linearity. A correction unit reads the bank through a combinational port. When that unit runs a narrow 8-bit conversion, only the zero-error coefficient is visible to it.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, `busy_o` and `meas_req_o` are low and every coefficient slot reads zero.
- R2: A start seen while idle raises `busy_o` on the next cycle. `busy_o` stays high until the cycle after the last coefficient is written, and then falls.
- R3: An offset-only run (`full_i`=0 at start) makes exactly one measurement, with pattern 0x40. The returned error becomes coefficient slot 0 unchanged, and slots 1 to 13 keep their previous values.
- R4: A full run (`full_i`=1 at start) makes 112 measurements. The first 8 use pattern 0x40 (zero-error step). Then come 8 measurements for each capacitor k, taken in the order k = 12 down to 0, with pattern 0x80 | k.
- R5: In a full run each stored coefficient is the signed sum of its eight errors shifted right arithmetically by 3, which is floor(sum/8).
- R6: Slot 0 holds the zero-error coefficient and slot k+1 holds capacitor k's coefficient. Slots 14 and 15 read zero.
- R7: While `narrow_i` is 1, slots 1 to 13 read zero and slot 0 still reads the zero-error coefficient.
- R8: A start given while busy is ignored. The run in progress keeps its mode and makes the same number of measurements with the same results.
- R9: Each request is a single-cycle pulse, issued only while busy. No new request is issued until the previous result has been accepted, and `dac_pat_o` holds steady while a result is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| full_i | input | 1 | Run type sampled at start: 1 full, 0 offset-only |
| busy_o | output | 1 | Calibration in progress |
| meas_req_o | output | 1 | One-cycle measurement request |
| dac_pat_o | output | 8 | DAC test setting for the current measurement |
| res_valid_i | input | 1 | Measurement result valid |
| res_err_i | input | 8 | Signed error count of the measurement |
| narrow_i | input | 1 | Reader is in an 8-bit mode |
| rd_slot_i | input | 4 | Coefficient slot to read |
| rd_coef_o | output | 8 | Signed coefficient of the selected slot |

## Verification
Every cycle, the embedded properties check the request handshake: single-cycle pulses, requests only while busy, and a stable pattern while a result is awaited. They also check that busy only rises after a start, that the run type stays fixed during a run, and that offset-only runs write nothing but slot 0. The step order, the floor-rounded averages at the extreme error values, the preservation of linearity slots across a short run, and the narrow read masking only show up in the bench's sweeps, where a modelled error source feeds varying per-step and per-repeat errors.

// File: rtl/calctl_pkg.sv
// Package: shared state type, pattern kind codes and the pattern ROM word function.
// Assumes capacitor indices fit in 4 bits.
package calctl_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_STORE} cal_state_t;

    localparam logic [1:0] K_OFS = 2'b01;
    localparam logic [1:0] K_CAP = 2'b10;
    localparam logic [1:0] K_END = 2'b11;

    // Word idx: 0 = zero-error step, 1..ncap = capacitor ncap-idx, rest = end marker.
    function automatic logic [7:0] rom_word(input int unsigned idx, input int unsigned ncap);
        if (idx == 0)
            return {K_OFS, 6'd0};
        else if (idx <= ncap)
            return {K_CAP, 2'b00, 4'(ncap - idx)};
        else
            return {K_END, 6'd0};
    endfunction
endpackage

// File: rtl/cal_rom.sv
// Module: cal_rom - constant pattern table, DEPTH words of 8 bits, combinational read.
// Assumes DEPTH >= NCAP + 2 so that at least one end marker exists.
module cal_rom #(
    parameter int NCAP  = 13,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    word_o
);
    import calctl_pkg::*;

    logic [7:0] tbl [DEPTH];

    // Fill each table word from the generator function.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign tbl[g] = rom_word(g, NCAP);
    end

    // Look up the addressed word.
    assign word_o = tbl[addr_i];
endmodule

// File: rtl/cal_accum.sv
// Module: cal_accum - signed sum of error counts, reduced to a floor average or passed through.
// Assumes at most 2**RLOG additions between clears.
module cal_accum #(
    parameter int EW   = 8,
    parameter int RLOG = 3,
    localparam int SW  = EW + RLOG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 add_i,
    input  logic signed [EW-1:0] din_i,
    input  logic                 avg_i,
    output logic signed [EW-1:0] coef_o
);
    logic signed [SW-1:0] sum_q;
    logic signed [SW-1:0] shifted;

    // Clear or add one sign-extended sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            sum_q <= '0;
        else if (add_i)
            sum_q <= sum_q + {{RLOG{din_i[EW-1]}}, din_i};
    end

    // Arithmetic shift rounds toward minus infinity.
    always_comb begin
        shifted = sum_q >>> RLOG;
        coef_o  = avg_i ? shifted[EW-1:0] : sum_q[EW-1:0];
    end
endmodule

// File: rtl/cal_coef_bank.sv
// Module: cal_coef_bank - zero-error slot 0 plus NCAP linearity slots, one write port, one read port.
// Assumes a narrow reader must see only slot 0.
module cal_coef_bank #(
    parameter int EW    = 8,
    parameter int NCAP  = 13,
    localparam int NSLOT = NCAP + 1,
    localparam int SLW   = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [SLW-1:0]       wr_slot_i,
    input  logic signed [EW-1:0] wr_val_i,
    input  logic                 narrow_i,
    input  logic [SLW-1:0]       rd_slot_i,
    output logic signed [EW-1:0] rd_coef_o
);
    logic signed [EW-1:0] coef_q [NSLOT];

    // Clear all slots on reset, else write the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) coef_q[i] <= '0;
        end else if (wr_en_i && (int'(wr_slot_i) < NSLOT)) begin
            coef_q[wr_slot_i] <= wr_val_i;
        end
    end

    // Read with range check and narrow-mode masking of linearity slots.
    always_comb begin
        rd_coef_o = '0;
        if (int'(rd_slot_i) < NSLOT && (rd_slot_i == '0 || !narrow_i))
            rd_coef_o = coef_q[rd_slot_i];
    end
endmodule

// File: rtl/cal_seq_ctrl.sv
// Module: cal_seq_ctrl - calibration sequencer: walks the pattern ROM, requests measurements,
// accumulates results and stores coefficients. Assumes the error source answers each request
// once with res_valid_i, never while no request is outstanding.
module cal_seq_ctrl #(
    parameter int EW        = 8,
    parameter int NCAP      = 13,
    parameter int RLOG      = 3,
    parameter int ROM_DEPTH = 16,
    localparam int NSLOT    = NCAP + 1,
    localparam int SLW      = $clog2(NSLOT),
    localparam int AW       = $clog2(ROM_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 full_i,
    output logic                 busy_o,
    output logic                 meas_req_o,
    output logic [7:0]           dac_pat_o,
    input  logic                 res_valid_i,
    input  logic signed [EW-1:0] res_err_i,
    input  logic                 narrow_i,
    input  logic [SLW-1:0]       rd_slot_i,
    output logic signed [EW-1:0] rd_coef_o
);
    import calctl_pkg::*;

    cal_state_t      state_q;
    logic [AW-1:0]   step_q;
    logic [RLOG-1:0] rep_q;
    logic            full_q;
    logic [7:0]      cur_word;
    logic [7:0]      nxt_word;
    logic            last_rep;
    logic            run_done;
    logic            acc_clr;
    logic            acc_add;
    logic            wr_en;
    logic [SLW-1:0]  wr_slot;
    logic signed [EW-1:0] wr_val;
    logic            unused_pat_bits;

    // Current step pattern and a peek at the following one.
    cal_rom #(.NCAP(NCAP), .DEPTH(ROM_DEPTH)) u_rom_cur (.addr_i(step_q), .word_o(cur_word));
    cal_rom #(.NCAP(NCAP), .DEPTH(ROM_DEPTH)) u_rom_nxt (.addr_i(step_q + AW'(1)), .word_o(nxt_word));

    // Step-level decisions: repeat count and end of run.
    always_comb begin
        last_rep = full_q ? (rep_q == {RLOG{1'b1}}) : 1'b1;
        run_done = !full_q || (nxt_word[7:6] == K_END);
    end

    // Main sequencer: idle, issue request, wait for result, store coefficient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            rep_q   <= '0;
            full_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_ISSUE;
                    step_q  <= '0;
                    rep_q   <= '0;
                    full_q  <= full_i;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (res_valid_i) begin
                    if (last_rep) begin
                        state_q <= ST_STORE;
                    end else begin
                        rep_q   <= rep_q + RLOG'(1);
                        state_q <= ST_ISSUE;
                    end
                end
                ST_STORE: begin
                    rep_q  <= '0;
                    step_q <= step_q + AW'(1);
                    state_q <= run_done ? ST_IDLE : ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath controls and write-slot decode from the pattern fields.
    always_comb begin
        acc_clr    = (state_q == ST_IDLE && start_i) || state_q == ST_STORE;
        acc_add    = (state_q == ST_WAIT) && res_valid_i;
        wr_en      = (state_q == ST_STORE);
        wr_slot    = (cur_word[7:6] == K_OFS) ? '0 : (SLW'(cur_word[3:0]) + SLW'(1));
        busy_o     = (state_q != ST_IDLE);
        meas_req_o = (state_q == ST_ISSUE);
        dac_pat_o  = cur_word;
    end
    assign unused_pat_bits = ^cur_word[5:4];

    cal_accum #(.EW(EW), .RLOG(RLOG)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .add_i(acc_add),
        .din_i(res_err_i), .avg_i(full_q), .coef_o(wr_val)
    );

    cal_coef_bank #(.EW(EW), .NCAP(NCAP)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_slot_i(wr_slot),
        .wr_val_i(wr_val), .narrow_i(narrow_i), .rd_slot_i(rd_slot_i), .rd_coef_o(rd_coef_o)
    );

    // Requests only inside a run.
    p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |-> busy_o);
    // Requests are single-cycle pulses.
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |=> !meas_req_o);
    // Pattern holds while a result is awaited.
    p_pat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> $stable(dac_pat_o));
    // Busy rises only in response to a start.
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // Run type is frozen during a run.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(full_q));
    // Short runs only touch slot 0.
    p_ofs_only_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_q) |-> (wr_slot == '0));
endmodule

// File: tb/sim_cal_seq_ctrl.sv
// Bench for cal_seq_ctrl: models the error source arithmetically and sweeps run types and error sets.
module sim_cal_seq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, full_i = 1'b0, res_valid_i = 1'b0, narrow_i = 1'b0;
    logic signed [7:0] res_err_i = '0;
    logic [3:0] rd_slot_i = '0;
    logic busy_o, meas_req_o;
    logic [7:0] dac_pat_o;
    logic signed [7:0] rd_coef_o;

    int checks = 0, errors = 0;
    int exp_coef [14];
    int done_flag = 0;

    always #2 clk = ~clk;

    cal_seq_ctrl u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
        .busy_o(busy_o), .meas_req_o(meas_req_o), .dac_pat_o(dac_pat_o),
        .res_valid_i(res_valid_i), .res_err_i(res_err_i), .narrow_i(narrow_i),
        .rd_slot_i(rd_slot_i), .rd_coef_o(rd_coef_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Error source: target t (0 zero error, k+1 capacitor k), repeat r, scenario s.
    function automatic int err_of(input int t, input int r, input int s);
        int v;
        if (s == 100) return 127;
        if (s == 101) return -128;
        v = ((s * 29 + t * 17) % 200) - 100 + ((r * 37 + t * 11 + s) % 23) - 11;
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        return v;
    endfunction

    task automatic read_all(input string tag);
        for (int s = 0; s < 16; s++) begin
            rd_slot_i = 4'(s);
            narrow_i = 1'b0;
            #1;
            check(tag, int'(rd_coef_o), (s < 14) ? exp_coef[s] : 0);
            narrow_i = 1'b1;
            #1;
            check("R7 narrow read", int'(rd_coef_o), (s == 0) ? exp_coef[0] : 0);
        end
        narrow_i = 1'b0;
    endtask

    // One run: start, answer every request, check patterns and count.
    task automatic run_cal(input bit full, input int scen, input int lat, input bit poke);
        int nreq = 0;
        int reps [14];
        int sums [14];
        int t;
        for (int i = 0; i < 14; i++) begin reps[i] = 0; sums[i] = 0; end
        @(negedge clk);
        full_i = full; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", int'(busy_o), 1);
        forever begin
            if (!busy_o) break;
            if (meas_req_o) begin
                if (full) check("R4 pattern order", int'(dac_pat_o),
                                (nreq / 8 == 0) ? 'h40 : ('h80 | (13 - nreq / 8)));
                else check("R3 offset pattern", int'(dac_pat_o), 'h40);
                t = (dac_pat_o[7:6] == 2'b01) ? 0 : int'(dac_pat_o[3:0]) + 1;
                nreq++;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    check("R9 one request per result", int'(meas_req_o), 0);
                    if (poke && nreq == 3 && w == 0) begin
                        start_i = 1'b1; full_i = ~full;  // R8 stimulus
                    end else start_i = 1'b0;
                end
                start_i = 1'b0;
                res_err_i = 8'(err_of(t, reps[t], scen));
                sums[t] += err_of(t, reps[t], scen);
                reps[t]++;
                res_valid_i = 1'b1;
                @(negedge clk);
                res_valid_i = 1'b0;
                if (full ? (reps[t] == 8) : 1'b1)
                    check("R2 busy during store", int'(busy_o), 1);
            end else @(negedge clk);
        end
        check(poke ? "R8 count unchanged" : (full ? "R4 request count" : "R3 request count"),
              nreq, full ? 112 : 1);
        if (full) for (int i = 0; i < 14; i++) exp_coef[i] = sums[i] >>> 3;  // R5
        else exp_coef[0] = err_of(0, 0, scen);
        read_all(full ? "R5 R6 coefficient" : "R3 slot values");
    endtask

    initial begin
        for (int i = 0; i < 14; i++) exp_coef[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 req reset", int'(meas_req_o), 0);
        read_all("R1 slot reset");
        run_cal(1'b0, 7, 1, 1'b0);
        run_cal(1'b1, 1, 1, 1'b0);
        run_cal(1'b1, 2, 3, 1'b1);
        run_cal(1'b0, 9, 2, 1'b0);
        run_cal(1'b1, 100, 1, 1'b0);
        run_cal(1'b1, 101, 2, 1'b0);
        for (int s = 3; s < 7; s++) run_cal(1'b1, s, 1 + s % 3, 1'b0);
        run_cal(1'b0, 42, 4, 1'b0);
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag == 1);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule